// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Engine

This block reproduces the data-side behaviour of a synchronous DRAM on a single open row. A controller issues read, write and precharge commands together with a start column; the engine walks the column sequence of the burst on its own, one column per clock, and writes or reads a small internal row array. Read data is delayed by the programmed CAS latency and presented with a per-byte output enable. Write data is taken in the same cycle as the command that carries the column.

Per-byte masking follows the usual DRAM rule. A mask bit blocks its byte lane of write data in the same cycle it is presented. On reads, the same bit blurs the lane two cycles after it is sampled, whatever the CAS latency. A running burst can be replaced by a new read or write, or stopped with a precharge. Read beats that were already launched into the latency pipeline still come out, so two reads can be chained without a gap on the output. Row and bank timing are left to the controller.

Top module: `sdr_burst_engine`

## Requirements
- R1: After reset every rd_oe_o bit is 0, rdata_o is 0 and every stored word of the row is 0.
- R2: bl_code_i is sampled with each read or write command; codes 0, 1, 2, 3 give bursts of 1, 2, 4 and 8 beats, one beat per cycle, starting in the command cycle.
- R3: With intlv_i = 0 (sequential), beat k of a burst of length L starting at column s uses column (s with its low log2(L) bits cleared) plus ((s + k) mod L), so the burst wraps inside its L-aligned block.
- R4: With intlv_i = 1 (interleaved), beat k uses column s XOR k.
- R5: The write data for beat 0 is taken in the command cycle; each later write beat takes wdata_i of its own cycle.
- R6: The data of read beat k is on rdata_o with its lane enables set in cycle t + CL + k, where t is the command cycle and CL is cl_i (values 1 to 3; 0 acts as 1).
- R7: After the last read beat rd_oe_o returns to 0, unless a further read command was issued so that its first beat follows without a gap.
- R8: A read or write command during a burst ends the old burst at once and starts the new one in that cycle; read beats already launched still appear.
- R9: A precharge command (cmd_i = 3) ends the current burst: no beat occurs in that cycle or later until a new command.
- R10: During a write beat, dqm_i bit n = 1 leaves byte n (bits 8n+7 down to 8n) of the addressed word unchanged.
- R11: dqm_i bit n = 1 sampled in cycle t forces rd_oe_o[n] = 0 and rdata_o bits 8n+7 down to 8n to 0 in cycle t + 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 none, 1 read, 2 write, 3 precharge |
| col_i | input | COL_W | Start column of a read or write |
| bl_code_i | input | 2 | Burst length code (1, 2, 4, 8 beats) |
| cl_i | input | CL_W | CAS latency in cycles |
| intlv_i | input | 1 | 1 selects interleaved order, 0 sequential |
| dqm_i | input | DATA_W/8 | Per-byte mask |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, zero on disabled lanes |
| rd_oe_o | output | DATA_W/8 | Per-byte output enable for read data |

## Verification
The bench builds the engine with its defaults: a 64-column row of 32-bit words and a latency pipeline three stages deep. The row then holds eight aligned 8-beat blocks, so every start offset and wrap point of every burst length can be hit and the reference model can tell a wrapped column from a carried one. With all three latencies reachable, the bench chains reads and overlaps the fixed two-cycle read mask with each of them, and random phases interrupt bursts with reads, writes and precharges.

// File: rtl/sdr_burst_pkg.sv
`timescale 1ns/1ps
package sdr_burst_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } burst_cmd_e;

    // Beat counter covers lengths up to 8.
    localparam int CNT_W = 3;

    typedef logic [CNT_W:0] beat_cnt_t;

    // Length code to beat count: 1, 2, 4, 8.
    function automatic beat_cnt_t len_of_code(input logic [1:0] code);
        return beat_cnt_t'(1) << code;
    endfunction

endpackage

// File: rtl/sdr_burst_seq.sv
`timescale 1ns/1ps
module sdr_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       bl_code_i,
    input  logic             intlv_i,
    output logic             beat_vld_o,
    output logic             beat_rd_o,
    output logic [COL_W-1:0] beat_col_o
);

    typedef struct packed {
        logic             act;
        logic             rd;
        logic             il;
        logic [COL_W-1:0] start;
        beat_cnt_t        cnt;
        beat_cnt_t        len;
    } seq_s;

    seq_s       st_d, st_q;
    burst_cmd_e cmd;

    assign cmd = burst_cmd_e'(cmd_i);

    // Column of beat k in a burst of n beats from column s.
    function automatic logic [COL_W-1:0] walk_col(
        input logic [COL_W-1:0] s,
        input beat_cnt_t        k,
        input beat_cnt_t        n,
        input logic             il
    );
        logic [COL_W-1:0] low_mask;
        logic [COL_W-1:0] step;
        low_mask = COL_W'(n - 1'b1);
        step     = COL_W'(k);
        if (il) begin
            return s ^ step;
        end
        return (s & ~low_mask) | ((s + step) & low_mask);
    endfunction

    always_comb begin
        st_d       = st_q;
        beat_vld_o = 1'b0;
        beat_rd_o  = 1'b0;
        beat_col_o = col_i;
        unique case (cmd)
            CMD_RD, CMD_WR: begin
                beat_vld_o = 1'b1;
                beat_rd_o  = (cmd == CMD_RD);
                beat_col_o = col_i;
                st_d.len   = len_of_code(bl_code_i);
                st_d.il    = intlv_i;
                st_d.rd    = (cmd == CMD_RD);
                st_d.start = col_i;
                st_d.cnt   = beat_cnt_t'(1);
                st_d.act   = (len_of_code(bl_code_i) != beat_cnt_t'(1));
            end
            CMD_PRE: begin
                st_d.act = 1'b0;
            end
            default: begin
                if (st_q.act) begin
                    beat_vld_o = 1'b1;
                    beat_rd_o  = st_q.rd;
                    beat_col_o = walk_col(st_q.start, st_q.cnt, st_q.len, st_q.il);
                    st_d.cnt   = st_q.cnt + 1'b1;
                    st_d.act   = ((st_q.cnt + 1'b1) != st_q.len);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an open burst always has beats left to run
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act |-> (st_q.cnt != '0) && (st_q.cnt < st_q.len));

    // R3: continuation beats stay inside the aligned block of the start column
    p_same_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && cmd == CMD_NOP) |->
            (((beat_col_o ^ st_q.start) & ~COL_W'(st_q.len - 1'b1)) == '0));

    // R5: a write command lands its first beat on its own column
    p_wr_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |-> (beat_vld_o && !beat_rd_o && beat_col_o == col_i));

    // R9: after a precharge, an idle cycle carries no beat
    p_pre_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) ##1 (cmd == CMD_NOP) |-> !beat_vld_o);

endmodule

// File: rtl/sdr_row_store.sv
`timescale 1ns/1ps
module sdr_row_store #(
    parameter int COL_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [COL_W-1:0]    col_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [DATA_W/8-1:0] wr_mask_i,
    output logic [DATA_W-1:0]   rd_data_o
);

    localparam int DEPTH = 1 << COL_W;
    localparam int NB    = DATA_W / 8;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            for (int b = 0; b < NB; b++) begin
                if (!wr_mask_i[b]) begin
                    mem_d[col_i][8*b +: 8] = wr_data_i[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[col_i];

    for (genvar gb = 0; gb < NB; gb++) begin : g_lane_chk
        // R10: a masked lane keeps its stored byte
        p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_mask_i[gb]) |=>
                (mem_q[$past(col_i)][8*gb +: 8] == $past(mem_q[col_i][8*gb +: 8])));

        // R5: an open lane stores the data of the beat cycle
        p_write_land_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !wr_mask_i[gb]) |=>
                (mem_q[$past(col_i)][8*gb +: 8] == $past(wr_data_i[8*gb +: 8])));
    end

endmodule

// File: rtl/sdr_read_pipe.sv
`timescale 1ns/1ps
module sdr_read_pipe #(
    parameter int DATA_W = 32,
    parameter int MAX_CL = 3,
    parameter int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                beat_vld_i,
    input  logic [DATA_W-1:0]   beat_data_i,
    input  logic [CL_W-1:0]     cl_i,
    input  logic [DATA_W/8-1:0] dqm_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [DATA_W/8-1:0] oe_o
);

    localparam int NB = DATA_W / 8;

    typedef struct packed {
        logic [MAX_CL-1:0]             vld;
        logic [MAX_CL-1:0][DATA_W-1:0] dat;
        logic [NB-1:0]                 dqm1;
        logic [NB-1:0]                 dqm2;
    } pipe_s;

    pipe_s           st_d, st_q;
    logic [CL_W-1:0] tap;
    logic            hit;
    logic [NB-1:0]   lane_on;

    // Tap of the delay line that matches the latency; 0 acts as 1.
    always_comb begin
        if (cl_i == '0) begin
            tap = '0;
        end else if (cl_i > CL_W'(MAX_CL)) begin
            tap = CL_W'(MAX_CL - 1);
        end else begin
            tap = cl_i - 1'b1;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = {st_q.vld[MAX_CL-2:0], beat_vld_i};
        st_d.dat  = {st_q.dat[MAX_CL-2:0], beat_data_i};
        st_d.dqm1 = dqm_i;
        st_d.dqm2 = st_q.dqm1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        hit = st_q.vld[tap];
        for (int b = 0; b < NB; b++) begin
            lane_on[b]          = hit & ~st_q.dqm2[b];
            rdata_o[8*b +: 8]   = lane_on[b] ? st_q.dat[tap][8*b +: 8] : 8'h00;
        end
        oe_o = lane_on;
    end

    // Edges seen since reset, so the mask check never reaches before it.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R11: a mask sampled two cycles back shuts its read lanes
    p_read_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> ((oe_o & $past(dqm_i, 2)) == '0));

    // R11: a shut lane drives zero data
    p_shut_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o == '0) |-> (rdata_o == '0));

endmodule

// File: rtl/sdr_burst_engine.sv
`timescale 1ns/1ps
module sdr_burst_engine #(
    parameter int COL_W  = 6,
    parameter int DATA_W = 32,
    parameter int MAX_CL = 3,
    parameter int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cmd_i,
    input  logic [COL_W-1:0]    col_i,
    input  logic [1:0]          bl_code_i,
    input  logic [CL_W-1:0]     cl_i,
    input  logic                intlv_i,
    input  logic [DATA_W/8-1:0] dqm_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [DATA_W/8-1:0] rd_oe_o
);

    logic              beat_vld;
    logic              beat_rd;
    logic [COL_W-1:0]  beat_col;
    logic [DATA_W-1:0] row_word;

    sdr_burst_seq #(
        .COL_W (COL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .col_i      (col_i),
        .bl_code_i  (bl_code_i),
        .intlv_i    (intlv_i),
        .beat_vld_o (beat_vld),
        .beat_rd_o  (beat_rd),
        .beat_col_o (beat_col)
    );

    sdr_row_store #(
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (beat_vld && !beat_rd),
        .col_i     (beat_col),
        .wr_data_i (wdata_i),
        .wr_mask_i (dqm_i),
        .rd_data_o (row_word)
    );

    sdr_read_pipe #(
        .DATA_W (DATA_W),
        .MAX_CL (MAX_CL),
        .CL_W   (CL_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_vld_i  (beat_vld && beat_rd),
        .beat_data_i (row_word),
        .cl_i        (cl_i),
        .dqm_i       (dqm_i),
        .rdata_o     (rdata_o),
        .oe_o        (rd_oe_o)
    );

endmodule

// File: tb/sdr_burst_engine_test.sv
`timescale 1ns/1ps
module sdr_burst_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [5:0]  col = '0;
    logic [1:0]  bl = 2'd0;
    logic [1:0]  cl = 2'd1;
    logic        il = 1'b0;
    logic [3:0]  dqm = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic [3:0]  oe;

    always #2.5 clk = ~clk;

    sdr_burst_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(col), .bl_code_i(bl),
        .cl_i(cl), .intlv_i(il), .dqm_i(dqm), .wdata_i(wd),
        .rdata_o(rdata), .rd_oe_o(oe)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R1";

    // Reference model state.
    logic [31:0] mm [64];
    bit          m_act = 0, m_rd = 0, m_il = 0;
    int          m_start = 0, m_cnt = 0, m_len = 1;
    bit          exp_vld [int];
    logic [31:0] exp_raw [int];
    logic [3:0]  dqm_hist [int];

    function automatic int model_col(int s, int k, int n, bit ilv);
        int base;
        if (ilv) return s ^ k;
        base = s - (s % n);
        return base + ((s % n) + k) % n;
    endfunction

    task automatic model_step();
        bit beat = 0;
        bit rd = 0;
        int c = 0;
        int lat = (cl == 2'd0) ? 1 : int'(cl);
        dqm_hist[cyc] = dqm;
        if (cmd == 2'd1 || cmd == 2'd2) begin
            m_len = 1 << bl; m_il = il; m_start = col; m_rd = (cmd == 2'd1);
            m_cnt = 1; m_act = (m_len > 1);
            beat = 1; rd = m_rd; c = col;
        end else if (cmd == 2'd3) begin
            m_act = 0;
        end else if (m_act) begin
            beat = 1; rd = m_rd; c = model_col(m_start, m_cnt, m_len, m_il);
            m_cnt++;
            if (m_cnt == m_len) m_act = 0;
        end
        if (beat && rd) begin
            exp_vld[cyc + lat] = 1;
            exp_raw[cyc + lat] = mm[c];
        end
        if (beat && !rd) begin
            for (int b = 0; b < 4; b++)
                if (!dqm[b]) mm[c][8*b +: 8] = wd[8*b +: 8];
        end
    endtask

    task automatic compare();
        bit          v = exp_vld.exists(cyc) ? exp_vld[cyc] : 0;
        logic [3:0]  m = dqm_hist.exists(cyc - 2) ? dqm_hist[cyc - 2] : 4'h0;
        logic [3:0]  e_oe = {4{v}} & ~m;
        logic [31:0] e_d = '0;
        if (v) begin
            for (int b = 0; b < 4; b++)
                if (e_oe[b]) e_d[8*b +: 8] = exp_raw[cyc][8*b +: 8];
        end
        n_chk++;
        if (rdata !== e_d || oe !== e_oe) begin
            n_fail++;
            $display("FAIL %s cycle %0d: rdata=%h oe=%b expected rdata=%h oe=%b",
                     tag, cyc, rdata, oe, e_d, e_oe);
        end
    endtask

    task automatic tick(input logic [1:0] c, input logic [5:0] a,
                        input logic [31:0] w, input logic [3:0] m);
        @(negedge clk);
        compare();
        cmd = c; col = a; wd = w; dqm = m;
        model_step();
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(2'd0, 6'd0, 32'h0, 4'h0);
    endtask

    task automatic wr_burst(input int s, input int beats, input logic [31:0] base);
        tick(2'd2, 6'(s), base, 4'h0);
        for (int k = 1; k < beats; k++) tick(2'd0, 6'd0, base + 32'(k), 4'h0);
    endtask

    task automatic rd_burst(input int s, input int beats);
        tick(2'd1, 6'(s), 32'h0, 4'h0);
        for (int k = 1; k < beats; k++) tick(2'd0, 6'd0, 32'h0, 4'h0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mm[i] = '0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (oe !== 4'h0 || rdata !== 32'h0) begin
            n_fail++;
            $display("FAIL R1 after reset: rdata=%h oe=%b expected rdata=0 oe=0", rdata, oe);
        end
        cyc++;
        dqm_hist[cyc - 1] = 4'h0;

        // R1: zeroed row reads back as zero
        tag = "R1"; bl = 2'd3; cl = 2'd2; il = 0;
        rd_burst(0, 8); idle(4);

        // R5 / R2: fill the row with eight 8-beat sequential writes
        tag = "R5";
        for (int blk = 0; blk < 8; blk++) wr_burst(blk * 8, 8, 32'hA000_0000 + 32'(blk << 8));
        idle(3);

        // R3: sequential wrap inside a 4-block
        tag = "R3"; bl = 2'd2;
        rd_burst(6, 4); rd_burst(13, 4); idle(4);
        bl = 2'd3; rd_burst(29, 8); idle(4);

        // R4: interleaved order
        tag = "R4"; il = 1; cl = 2'd3;
        rd_burst(5, 8); idle(2); bl = 2'd2; rd_burst(47, 4); idle(5);
        il = 0;

        // R2: lengths 1 and 2
        tag = "R2"; bl = 2'd0; cl = 2'd1;
        rd_burst(9, 1); idle(2); bl = 2'd1; rd_burst(19, 2); idle(3);

        // R6: each latency in turn
        tag = "R6"; bl = 2'd2;
        for (int l = 1; l <= 3; l++) begin
            cl = 2'(l); rd_burst(32, 4); idle(5);
        end
        cl = 2'd0; rd_burst(40, 4); idle(5);

        // R7: chained reads without a gap, then the enable drops
        tag = "R7"; cl = 2'd2;
        rd_burst(8, 4); rd_burst(20, 4); rd_burst(60, 4); idle(6);

        // R8: read cut by read, write cut by write, read cut by write
        tag = "R8"; bl = 2'd3;
        rd_burst(0, 3); rd_burst(48, 8); idle(4);
        wr_burst(16, 3, 32'h5555_0000); wr_burst(40, 2, 32'h6666_0000); idle(3);
        rd_burst(16, 8); rd_burst(40, 8); idle(4);
        rd_burst(24, 2); wr_burst(56, 1, 32'h7777_7777); idle(6);

        // R9: precharge stops a burst
        tag = "R9";
        rd_burst(8, 3); tick(2'd3, 6'd0, 32'h0, 4'h0); idle(8);
        wr_burst(0, 2, 32'h9999_0000); tick(2'd3, 6'd0, 32'h0, 4'h0); idle(8);
        rd_burst(0, 8); idle(4);

        // R10: write masking per byte
        tag = "R10";
        tick(2'd2, 6'd32, 32'h1111_1111, 4'b0001);
        tick(2'd0, 6'd0, 32'h2222_2222, 4'b0110);
        tick(2'd0, 6'd0, 32'h3333_3333, 4'b1000);
        tick(2'd0, 6'd0, 32'h4444_4444, 4'b1111);
        tick(2'd0, 6'd0, 32'h5555_5555, 4'b0000);
        idle(4); rd_burst(32, 8); idle(4);

        // R11: read masking two cycles after sampling
        tag = "R11";
        for (int l = 1; l <= 3; l++) begin
            cl = 2'(l);
            tick(2'd1, 6'd32, 32'h0, 4'b0011);
            tick(2'd0, 6'd0, 32'h0, 4'b0000);
            tick(2'd0, 6'd0, 32'h0, 4'b1100);
            tick(2'd0, 6'd0, 32'h0, 4'b0101);
            for (int k = 0; k < 6; k++) tick(2'd0, 6'd0, 32'h0, 4'(k + 6));
            idle(4);
        end

        // Random mixes of all commands across modes
        tag = "R8";
        for (int ph = 0; ph < 10; ph++) begin
            bl = 2'($urandom_range(0, 3));
            il = 1'($urandom_range(0, 1));
            cl = 2'($urandom_range(1, 3));
            for (int i = 0; i < 150; i++) begin
                int r = $urandom_range(0, 99);
                logic [1:0] c = (r < 60) ? 2'd0 : (r < 75) ? 2'd1 : (r < 90) ? 2'd2 : 2'd3;
                logic [3:0] m = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
                tick(c, 6'($urandom()), 32'($urandom()), m);
            end
            idle(6);
        end

        idle(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): run still busy, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule